// File: doc/BRIEF.md
# Bulk List Current Pointer Tracker

This block keeps the position of a host controller's walk through its bulk transfer list. It holds the list head address, the current endpoint-descriptor address and a list-enable bit, all reachable through a small host-software register port. It also keeps the flag that marks the list as having new work. The scheduler drives a list-walk interface. It reports when a descriptor has been served, together with that descriptor's link to the next one. It reports when it has run off the end of the list. It also passes on a request from software to set the new-work flag.

The current pointer moves forward one link per served descriptor. It keeps its value between frames, so the walk resumes where it stopped. At the end of the list the pointer goes back to the head only when the new-work flag is set, and that reload clears the flag. Software may rewrite the current pointer only while the list is disabled. Addresses are 16-byte aligned, so the four low bits of both pointer registers are reserved and always zero.

Top module: `bulk_cur_tracker`

## Requirements
- R1: After reset the current pointer, head pointer, enable bit and new-work flag are all zero. A current pointer of zero means end of list.
- R2: Bits 3:0 of the head and current pointers always read as zero, and writes to those bits have no effect. Only bits 31:4 are stored.
- R3: A served event loads the current pointer with bits 31:4 of the supplied next link in the next cycle. With no event the pointer holds its value across any number of cycles.
- R4: An end-of-list event while the new-work flag is clear leaves both the current pointer and the flag unchanged.
- R5: An end-of-list event while the new-work flag is set copies the head pointer into the current pointer and clears the flag.
- R6: A software write to the current pointer (select 2) is accepted only while the enable bit is 0. While the enable bit is 1 such a write is dropped, and a read of select 2 returns the live pointer.
- R7: A served event whose next link has bits 31:4 equal to zero counts as an end-of-list event in the same cycle. With the flag set it reloads from the head. With the flag clear it leaves the pointer at zero.
- R8: When a new-work set request and a flag-clearing reload fall in the same cycle, the reload still happens and the flag ends up set.
- R9: Software may write the head pointer (select 1) at any time, whatever the enable bit.
- R10: The register port decodes a 2-bit select. Select 0 is the control word, with bit 0 the enable bit (read/write) and bit 1 the new-work flag (read-only), other bits reading zero. Select 1 is the head, select 2 is the current pointer, and select 3 reads zero. Read data is combinational from the select.
- R11: When a walk event and an accepted software write to the current pointer fall in the same cycle, the walk event decides the new pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| served_i | input | 1 | Current descriptor served |
| next_ptr_i | input | 32 | Next-descriptor link of the served descriptor |
| list_end_i | input | 1 | Scheduler reached the end of the list |
| fill_set_i | input | 1 | Set the new-work flag |
| cur_ptr_o | output | 32 | Current descriptor pointer |
| filled_o | output | 1 | New-work flag |
| list_en_o | output | 1 | Bulk list enable bit |

## Verification
All state is registered, and the read port is a mux with no register in it. Each write or walk event is therefore visible on the outputs and on the read port one rising edge after the cycle in which it was driven. The bench drives stimulus on the falling edge, holds it across exactly one rising edge, and samples at the following falling edge. Every expected value is due at that point. Hold checks let several further edges pass and then compare against the value that was sampled earlier.

// File: rtl/bulk_cur_pkg.sv
package bulk_cur_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned RSVD_W = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HEAD = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_FILL_BIT = 1;
endpackage

// File: rtl/bulk_ptr_reg.sv
module bulk_ptr_reg #(
  parameter int unsigned W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/bulk_fill_flag.sv
module bulk_fill_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates so work queued in the reload cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/bulk_walk_next.sv
module bulk_walk_next #(
  parameter int unsigned PTR_W = 28
) (
  input  logic             served_i,
  input  logic [PTR_W-1:0] next_i,
  input  logic             list_end_i,
  input  logic             filled_i,
  input  logic [PTR_W-1:0] head_i,
  input  logic             sw_wr_i,
  input  logic [PTR_W-1:0] sw_d_i,
  output logic             ld_o,
  output logic [PTR_W-1:0] d_o,
  output logic             clr_fill_o
);
  logic end_evt;
  logic reload;

  assign end_evt    = list_end_i | (served_i && next_i == '0);
  assign reload     = end_evt & filled_i;
  assign clr_fill_o = reload;
  assign ld_o       = reload | served_i | sw_wr_i;

  always_comb begin
    if (reload)        d_o = head_i;
    else if (served_i) d_o = next_i;
    else               d_o = sw_d_i;
  end
endmodule

// File: rtl/bulk_cur_tracker.sv
module bulk_cur_tracker
  import bulk_cur_pkg::*;
#(
  parameter int unsigned ADDR_W = REG_W,
  parameter int unsigned LOW_W  = RSVD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic              served_i,
  input  logic [ADDR_W-1:0] next_ptr_i,
  input  logic              list_end_i,
  input  logic              fill_set_i,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic              filled_o,
  output logic              list_en_o
);
  localparam int unsigned PTR_W = ADDR_W - LOW_W;

  logic [PTR_W-1:0] head_q, cur_q, cur_d;
  logic             cur_ld, clr_fill, en_q;
  logic             wr_head, wr_cur, wr_ctrl;
  logic             unused_bits;

  assign wr_ctrl = reg_we_i && reg_sel_e'(reg_sel_i) == SEL_CTRL;
  assign wr_head = reg_we_i && reg_sel_e'(reg_sel_i) == SEL_HEAD;
  assign wr_cur  = reg_we_i && reg_sel_e'(reg_sel_i) == SEL_CUR && !en_q;

  assign unused_bits = ^{reg_wdata_i[LOW_W-1:1], next_ptr_i[LOW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (wr_ctrl) en_q <= reg_wdata_i[CTRL_EN_BIT];
  end

  bulk_ptr_reg #(.W(PTR_W)) u_head (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (wr_head),
    .d_i   (reg_wdata_i[ADDR_W-1:LOW_W]),
    .q_o   (head_q)
  );

  bulk_walk_next #(.PTR_W(PTR_W)) u_next (
    .served_i  (served_i),
    .next_i    (next_ptr_i[ADDR_W-1:LOW_W]),
    .list_end_i(list_end_i),
    .filled_i  (filled_o),
    .head_i    (head_q),
    .sw_wr_i   (wr_cur),
    .sw_d_i    (reg_wdata_i[ADDR_W-1:LOW_W]),
    .ld_o      (cur_ld),
    .d_o       (cur_d),
    .clr_fill_o(clr_fill)
  );

  bulk_ptr_reg #(.W(PTR_W)) u_cur (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (cur_ld),
    .d_i   (cur_d),
    .q_o   (cur_q)
  );

  bulk_fill_flag u_fill (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (fill_set_i),
    .clr_i (clr_fill),
    .q_o   (filled_o)
  );

  assign cur_ptr_o = {cur_q, {LOW_W{1'b0}}};
  assign list_en_o = en_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_e'(reg_sel_i))
      SEL_CTRL: begin
        reg_rdata_o[CTRL_EN_BIT]   = en_q;
        reg_rdata_o[CTRL_FILL_BIT] = filled_o;
      end
      SEL_HEAD: reg_rdata_o = {head_q, {LOW_W{1'b0}}};
      SEL_CUR:  reg_rdata_o = cur_ptr_o;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bulk_cur_tracker_chk.sv
module bulk_cur_tracker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LOW_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [ADDR_W-1:0] reg_wdata_i,
  input logic              served_i,
  input logic [ADDR_W-1:0] next_ptr_i,
  input logic              list_end_i,
  input logic              fill_set_i,
  input logic [ADDR_W-1:0] cur_ptr_o,
  input logic              filled_o,
  input logic              list_en_o
);
  logic [ADDR_W-1:0] mask;
  logic              nxt_zero;
  assign mask     = ~ADDR_W'((1 << LOW_W) - 1);
  assign nxt_zero = (next_ptr_i & mask) == '0;

  AST_SERVED_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    served_i && !nxt_zero && !list_end_i |=> cur_ptr_o == ($past(next_ptr_i) & mask)); // R3

  AST_END_NOFILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_end_i && !filled_o && !served_i && !fill_set_i && !reg_we_i
    |=> $stable(cur_ptr_o) && !filled_o); // R4

  AST_END_FILL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_end_i && filled_o && !fill_set_i |=> !filled_o); // R5

  AST_CUR_WR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_sel_i == 2'd2 && list_en_o && !served_i && !list_end_i
    |=> $stable(cur_ptr_o)); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_set_i |=> filled_o); // R8

  AST_RSVD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_ptr_o[LOW_W-1:0] == '0); // R2
endmodule

bind bulk_cur_tracker bulk_cur_tracker_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .served_i   (served_i),
  .next_ptr_i (next_ptr_i),
  .list_end_i (list_end_i),
  .fill_set_i (fill_set_i),
  .cur_ptr_o  (cur_ptr_o),
  .filled_o   (filled_o),
  .list_en_o  (list_en_o)
);

// File: tb/test_bulk_cur_tracker.sv
`timescale 1ns/1ps
module test_bulk_cur_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        served = 1'b0;
  logic [31:0] next_ptr = '0;
  logic        list_end = 1'b0;
  logic        fill_set = 1'b0;
  logic [31:0] cur_ptr;
  logic        filled;
  logic        list_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bulk_cur_tracker i_bulk_cur_tracker (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (reg_we),
    .reg_sel_i  (reg_sel),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .served_i   (served),
    .next_ptr_i (next_ptr),
    .list_end_i (list_end),
    .fill_set_i (fill_set),
    .cur_ptr_o  (cur_ptr),
    .filled_o   (filled),
    .list_en_o  (list_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle register write; result due at the next falling edge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic walk(input logic srv, input logic [31:0] nx, input logic le, input logic fs);
    served = srv; next_ptr = nx; list_end = le; fill_set = fs;
    @(negedge clk);
    served = 1'b0; next_ptr = '0; list_end = 1'b0; fill_set = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cur", cur_ptr, 32'h0);
    chk("R1 filled", {31'b0, filled}, 32'h0);
    chk("R1 en", {31'b0, list_en}, 32'h0);
    rd(2'd1, d); chk("R1 head", d, 32'h0);
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd1, 32'h1234_567F);
    rd(2'd1, d); chk("R2 head low bits", d, 32'h1234_5670);
    wr(2'd2, 32'hABCD_EF0F);
    rd(2'd2, d); chk("R2 cur low bits", d, 32'hABCD_EF00);
    chk("R2 cur port", cur_ptr, 32'hABCD_EF00);
    rd(2'd3, d); chk("R10 sel3 zero", d, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R10 ctrl en only", d, 32'h1);
    chk("R10 en port", {31'b0, list_en}, 32'h1);
  endtask

  task automatic t_served();
    logic [31:0] s;
    walk(1'b1, 32'h2000_0104, 1'b0, 1'b0);
    chk("R3 advance", cur_ptr, 32'h2000_0100);
    s = cur_ptr;
    repeat (5) @(negedge clk);
    chk("R3 hold between events", cur_ptr, s);
  endtask

  task automatic t_end_nofill();
    walk(1'b0, '0, 1'b1, 1'b0);
    chk("R4 cur unchanged", cur_ptr, 32'h2000_0100);
    chk("R4 flag stays clear", {31'b0, filled}, 32'h0);
  endtask

  task automatic t_end_fill();
    logic [31:0] d;
    walk(1'b0, '0, 1'b0, 1'b1);
    rd(2'd0, d); chk("R10 ctrl flag bit", d, 32'h3);
    walk(1'b0, '0, 1'b1, 1'b0);
    chk("R5 reload head", cur_ptr, 32'h1234_5670);
    chk("R5 flag cleared", {31'b0, filled}, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(2'd2, 32'h0000_5550);
    chk("R6 write dropped", cur_ptr, 32'h1234_5670);
    rd(2'd2, d); chk("R6 live read", d, 32'h1234_5670);
    wr(2'd1, 32'h0BAD_0010);
    rd(2'd1, d); chk("R9 head while enabled", d, 32'h0BAD_0010);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0000_5550);
    chk("R6 write accepted disabled", cur_ptr, 32'h0000_5550);
  endtask

  task automatic t_next_zero();
    walk(1'b0, '0, 1'b0, 1'b1);
    walk(1'b1, 32'h0000_0008, 1'b0, 1'b0);
    chk("R7 zero link reloads", cur_ptr, 32'h0BAD_0010);
    chk("R7 flag cleared", {31'b0, filled}, 32'h0);
    walk(1'b1, 32'h0000_0000, 1'b0, 1'b0);
    chk("R7 zero link no flag", cur_ptr, 32'h0);
    chk("R7 flag still clear", {31'b0, filled}, 32'h0);
  endtask

  task automatic t_race();
    walk(1'b0, '0, 1'b0, 1'b1);
    walk(1'b0, '0, 1'b1, 1'b1);
    chk("R8 reload happened", cur_ptr, 32'h0BAD_0010);
    chk("R8 set wins", {31'b0, filled}, 32'h1);
  endtask

  task automatic t_prio();
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h7777_7770;
    served = 1'b1; next_ptr = 32'h0000_3000;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; served = 1'b0; next_ptr = '0;
    chk("R11 walk beats write", cur_ptr, 32'h0000_3000);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_served();
    t_end_nofill();
    t_end_fill();
    t_gate();
    t_next_zero();
    t_race();
    t_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule